// File: doc/BRIEF.md
# RISC Integer Decode and Arithmetic Unit

This block turns one 32-bit instruction word into a register-file request and a computed result, with no clock and no state. It slices the word into either the register-register layout (opcode, two source indices, destination index, shift amount, function code) or the register-immediate layout (opcode, source index, destination index, 16-bit constant). It reports which registers to read, which register to write, and whether to write it. It also computes the 32-bit value to write from the two operand values the register file returns.

A surrounding pipeline drives the word in and feeds `rs_idx` and `rt_idx` to its register file. It returns the read data on `rs_val` and `rt_val`, then writes `result` to `dst_idx` when `wr_en` is high. Words outside the supported subset raise `illegal`, and the pipeline can trap on that flag. Memory access and control flow are handled elsewhere.

Top module: `risc_dec_alu`

## Requirements
- R1: `rs_idx` always equals instruction bits 25:21 and `rt_idx` always equals bits 20:16. For opcode (bits 31:26) 0x00 the destination is bits 15:11. For the immediate opcodes the destination is bits 20:16.
- R2: With opcode 0x00, the function code (bits 5:0) selects the operation. 0x20 gives rs_val+rt_val, 0x22 gives rs_val-rt_val, 0x24 gives AND, 0x25 gives OR and 0x26 gives XOR. Sums and differences wrap modulo 2^32.
- R3: With opcode 0x00, function 0x00 shifts rt_val left and function 0x02 shifts rt_val right, by the amount in bits 10:6. Vacated bits are filled with zeros in both directions.
- R4: With opcode 0x00, function 0x2A yields 1 when rs_val is less than rt_val as signed two's-complement numbers, and 0 otherwise.
- R5: Opcode 0x08 yields rs_val plus the sign-extended constant in bits 15:0, wrapping modulo 2^32.
- R6: Opcode 0x0D yields rs_val ORed with the zero-extended constant. When a load-upper result is fed back as rs_val, the pair forms any 32-bit constant.
- R7: Opcode 0x0F yields the constant in bits 31:16 with bits 15:0 cleared, whatever rs_val holds.
- R8: Any other opcode, or opcode 0x00 with any other function code, sets `illegal`, holds `wr_en` low, and drives `result` and `dst_idx` to 0.
- R9: A legal instruction whose destination index is 0 holds `wr_en` low. A legal instruction with a nonzero destination drives it high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| instr | input | 32 | Instruction word |
| rs_val | input | 32 | Value read from register `rs_idx` |
| rt_val | input | 32 | Value read from register `rt_idx` |
| rs_idx | output | 5 | First source register index |
| rt_idx | output | 5 | Second source register index |
| dst_idx | output | 5 | Destination register index |
| wr_en | output | 1 | Write the result to `dst_idx` |
| result | output | 32 | Computed value |
| illegal | output | 1 | Instruction not in the supported subset |

## Verification
All 64 opcodes are swept, and for opcode 0x00 all 64 function codes are swept too. This separates every decoded operation from every illegal code. Each word is paired with operands drawn from zero, one, the largest positive, the most negative, all-ones and a mixed pattern. This set exposes signed-versus-unsigned compare errors, carry and borrow wrap, and sign versus zero extension of the constants 0x7FFF, 0x8000 and 0xFFFF. The shift amount and the destination field vary with the sweep so that shifts by 0 and 31 and writes to register 0 all occur. A load-upper result fed into an or-immediate confirms that the pair builds a full 32-bit constant.

// File: rtl/rdalu_pkg.sv
`timescale 1ns/1ps
package rdalu_pkg;

    localparam int XLEN  = 32;
    localparam int RIDXW = 5;
    localparam int OPCW  = 6;
    localparam int FUNW  = 6;
    localparam int IMMW  = 16;
    localparam int HALFW = XLEN - IMMW;

    localparam logic [OPCW-1:0] OPC_REG  = 6'h00;
    localparam logic [OPCW-1:0] OPC_ADDI = 6'h08;
    localparam logic [OPCW-1:0] OPC_ORI  = 6'h0D;
    localparam logic [OPCW-1:0] OPC_LUI  = 6'h0F;

    localparam logic [FUNW-1:0] FN_SLL = 6'h00;
    localparam logic [FUNW-1:0] FN_SRL = 6'h02;
    localparam logic [FUNW-1:0] FN_ADD = 6'h20;
    localparam logic [FUNW-1:0] FN_SUB = 6'h22;
    localparam logic [FUNW-1:0] FN_AND = 6'h24;
    localparam logic [FUNW-1:0] FN_OR  = 6'h25;
    localparam logic [FUNW-1:0] FN_XOR = 6'h26;
    localparam logic [FUNW-1:0] FN_SLT = 6'h2A;

    typedef enum logic [3:0] {
        OP_NONE, OP_ADD, OP_SUB, OP_AND, OP_OR, OP_XOR,
        OP_SLL, OP_SRL, OP_SLT, OP_ADDI, OP_ORI, OP_LUI
    } alu_op_e;

    typedef struct packed {
        logic [OPCW-1:0]  opc;
        logic [RIDXW-1:0] src_a;
        logic [RIDXW-1:0] src_b;
        logic [RIDXW-1:0] dst;
        logic [RIDXW-1:0] amt;
        logic [FUNW-1:0]  fn;
    } reg_word_t;

    typedef struct packed {
        logic [OPCW-1:0]  opc;
        logic [RIDXW-1:0] src_a;
        logic [RIDXW-1:0] dst;
        logic [IMMW-1:0]  imm;
    } imm_word_t;

    typedef struct packed {
        alu_op_e          op;
        logic [RIDXW-1:0] dst;
        logic [RIDXW-1:0] amt;
        logic [XLEN-1:0]  konst;
        logic             bad;
    } ctl_t;

    function automatic logic [XLEN-1:0] sext_imm(input logic [IMMW-1:0] v);
        return {{HALFW{v[IMMW-1]}}, v};
    endfunction

    function automatic logic [XLEN-1:0] zext_imm(input logic [IMMW-1:0] v);
        return {{HALFW{1'b0}}, v};
    endfunction

endpackage

// File: rtl/rdalu_decode.sv
`timescale 1ns/1ps
module rdalu_decode
    import rdalu_pkg::*;
(
    input  logic [XLEN-1:0]  instr,
    output logic [RIDXW-1:0] rs_idx,
    output logic [RIDXW-1:0] rt_idx,
    output ctl_t             ctl
);
    reg_word_t rw;
    imm_word_t iw;

    assign rw     = reg_word_t'(instr);
    assign iw     = imm_word_t'(instr);
    assign rs_idx = rw.src_a;
    assign rt_idx = rw.src_b;

    always_comb begin
        ctl       = '0;
        ctl.op    = OP_NONE;
        ctl.amt   = rw.amt;
        ctl.konst = zext_imm(iw.imm);
        unique case (rw.opc)
            OPC_REG: begin
                ctl.dst = rw.dst;
                unique case (rw.fn)
                    FN_ADD:  ctl.op = OP_ADD;
                    FN_SUB:  ctl.op = OP_SUB;
                    FN_AND:  ctl.op = OP_AND;
                    FN_OR:   ctl.op = OP_OR;
                    FN_XOR:  ctl.op = OP_XOR;
                    FN_SLL:  ctl.op = OP_SLL;
                    FN_SRL:  ctl.op = OP_SRL;
                    FN_SLT:  ctl.op = OP_SLT;
                    default: ctl.bad = 1'b1;
                endcase
            end
            OPC_ADDI: begin
                ctl.op    = OP_ADDI;
                ctl.dst   = iw.dst;
                ctl.konst = sext_imm(iw.imm);
            end
            OPC_ORI: begin
                ctl.op  = OP_ORI;
                ctl.dst = iw.dst;
            end
            OPC_LUI: begin
                ctl.op  = OP_LUI;
                ctl.dst = iw.dst;
            end
            default: ctl.bad = 1'b1;
        endcase
        if (ctl.bad) ctl.dst = '0;
    end

    always_comb begin
        // R8
        bad_no_op_chk: assert (!ctl.bad || ctl.op == OP_NONE)
            else $error("illegal word decoded to an operation");
    end

endmodule

// File: rtl/rdalu_exec.sv
`timescale 1ns/1ps
module rdalu_exec
    import rdalu_pkg::*;
(
    input  ctl_t            ctl,
    input  logic [XLEN-1:0] opa,
    input  logic [XLEN-1:0] opb,
    output logic [XLEN-1:0] result
);
    always_comb begin
        unique case (ctl.op)
            OP_ADD:  result = opa + opb;
            OP_SUB:  result = opa - opb;
            OP_AND:  result = opa & opb;
            OP_OR:   result = opa | opb;
            OP_XOR:  result = opa ^ opb;
            OP_SLL:  result = opb << ctl.amt;
            OP_SRL:  result = opb >> ctl.amt;
            OP_SLT:  result = {{(XLEN-1){1'b0}}, ($signed(opa) < $signed(opb))};
            OP_ADDI: result = opa + ctl.konst;
            OP_ORI:  result = opa | ctl.konst;
            OP_LUI:  result = {ctl.konst[IMMW-1:0], {HALFW{1'b0}}};
            default: result = '0;
        endcase
    end

    always_comb begin
        // R7
        lui_low_clear_chk: assert (ctl.op != OP_LUI || result[HALFW-1:0] == '0)
            else $error("load-upper left low bits set");
        // R4
        slt_bool_chk: assert (ctl.op != OP_SLT || result[XLEN-1:1] == '0)
            else $error("set-less-than result not 0 or 1");
        // R3
        srl_fill_chk: assert (ctl.op != OP_SRL || ctl.amt == '0 || !result[XLEN-1])
            else $error("right shift did not zero-fill");
    end

endmodule

// File: rtl/risc_dec_alu.sv
`timescale 1ns/1ps
module risc_dec_alu
    import rdalu_pkg::*;
(
    input  logic [31:0] instr,
    input  logic [31:0] rs_val,
    input  logic [31:0] rt_val,
    output logic [4:0]  rs_idx,
    output logic [4:0]  rt_idx,
    output logic [4:0]  dst_idx,
    output logic        wr_en,
    output logic [31:0] result,
    output logic        illegal
);
    ctl_t ctl;

    rdalu_decode u_dec (
        .instr  (instr),
        .rs_idx (rs_idx),
        .rt_idx (rt_idx),
        .ctl    (ctl)
    );

    rdalu_exec u_exec (
        .ctl    (ctl),
        .opa    (rs_val),
        .opb    (rt_val),
        .result (result)
    );

    assign dst_idx = ctl.dst;
    assign illegal = ctl.bad;
    assign wr_en   = !ctl.bad && (ctl.dst != '0);

    always_comb begin
        // R8
        illegal_nowrite_chk: assert (!illegal || (!wr_en && result == '0))
            else $error("illegal word produced a write or result");
        // R9
        zero_dst_chk: assert (dst_idx != '0 || !wr_en)
            else $error("write enabled for register 0");
    end

endmodule

// File: tb/risc_dec_alu_test.sv
`timescale 1ns/1ps
module risc_dec_alu_test;

    logic clk = 1'b0;
    always #2.5 clk = ~clk;

    logic [31:0] instr, rs_val, rt_val, result;
    logic [4:0]  rs_idx, rt_idx, dst_idx;
    logic        wr_en, illegal;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    risc_dec_alu uut (
        .instr(instr), .rs_val(rs_val), .rt_val(rt_val),
        .rs_idx(rs_idx), .rt_idx(rt_idx), .dst_idx(dst_idx),
        .wr_en(wr_en), .result(result), .illegal(illegal)
    );

    logic [31:0] vals [6];
    logic [15:0] imms [6];

    // Reference from the requirements
    task automatic model(input logic [31:0] w, a, b,
                         output logic bad, output logic [4:0] d,
                         output logic [31:0] r, output string tag);
        logic [5:0]  opc;
        logic [5:0]  fn;
        logic [15:0] k;
        opc = w[31:26]; fn = w[5:0]; k = w[15:0];
        bad = 1'b0; r = 32'd0; d = w[15:11]; tag = "R2";
        if (opc == 6'h00) begin
            case (fn)
                6'h20: r = a + b;
                6'h22: r = a - b;
                6'h24: r = a & b;
                6'h25: r = a | b;
                6'h26: r = a ^ b;
                6'h00: begin r = b << w[10:6]; tag = "R3"; end
                6'h02: begin r = b >> w[10:6]; tag = "R3"; end
                6'h2A: begin
                    r = (($signed(a) < $signed(b)) ? 32'd1 : 32'd0); tag = "R4";
                end
                default: bad = 1'b1;
            endcase
        end else begin
            d = w[20:16];
            case (opc)
                6'h08: begin r = a + {{16{k[15]}}, k}; tag = "R5"; end
                6'h0D: begin r = a | {16'd0, k}; tag = "R6"; end
                6'h0F: begin r = {k, 16'd0}; tag = "R7"; end
                default: bad = 1'b1;
            endcase
        end
        if (bad) begin d = 5'd0; tag = "R8"; end
        else if (d == 5'd0) tag = "R9";
    endtask

    task automatic apply_and_check(input logic [31:0] w, a, b);
        logic        ebad;
        logic [4:0]  ed;
        logic [31:0] er;
        string       tag;
        logic        ewr;
        @(negedge clk);
        instr = w; rs_val = a; rt_val = b;
        #1;
        model(w, a, b, ebad, ed, er, tag);
        ewr = !ebad && (ed != 5'd0);
        checks++;
        if (rs_idx !== w[25:21] || rt_idx !== w[20:16]) begin
            fails++;
            $display("FAIL R1 instr=%h src idx act=%0d,%0d exp=%0d,%0d",
                     w, rs_idx, rt_idx, w[25:21], w[20:16]);
        end
        checks++;
        if (illegal !== ebad || dst_idx !== ed || wr_en !== ewr || result !== er) begin
            fails++;
            $display("FAIL %s instr=%h a=%h b=%h act ill=%b dst=%0d we=%b res=%h exp ill=%b dst=%0d we=%b res=%h",
                     tag, w, a, b, illegal, dst_idx, wr_en, result, ebad, ed, ewr, er);
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        logic [31:0] hi;
        vals = '{32'h0, 32'h1, 32'h7fffffff, 32'h80000000, 32'hffffffff, 32'h12345678};
        imms = '{16'h0000, 16'h0001, 16'h7fff, 16'h8000, 16'hffff, 16'h1234};
        instr = '0; rs_val = '0; rt_val = '0;

        // all-zero word: legal left shift into register 0, no write (R9)
        apply_and_check(32'h0, 32'h0, 32'h0);

        // R1..R9 sweep over every opcode and every function code
        for (int opc = 0; opc < 64; opc++) begin
            for (int fn = 0; fn < 64; fn++) begin
                if (opc != 0 && fn >= 6) continue;
                for (int i = 0; i < 6; i++) begin
                    for (int j = 0; j < 6; j++) begin
                        logic [4:0]  rsf, rtf, rdf, shf;
                        logic [31:0] w;
                        rsf = 5'((i * 7 + fn) % 32);
                        rtf = 5'((j * 3 + opc) % 32);
                        rdf = 5'((fn * 5 + i) % 32);
                        shf = (i == j) ? 5'd31 : 5'((i * 5 + j * 6) % 32);
                        if (opc == 0)
                            w = {6'(opc), rsf, rtf, rdf, shf, 6'(fn)};
                        else
                            w = {6'(opc), rsf, rtf, imms[(i + j + fn) % 6]};
                        apply_and_check(w, vals[i], vals[j]);
                    end
                end
            end
        end

        // R6: load-upper then or-immediate builds a full constant
        apply_and_check({6'h0F, 5'd3, 5'd9, 16'hdead}, 32'h5555_5555, 32'h0);
        hi = result;
        apply_and_check({6'h0D, 5'd9, 5'd9, 16'hbeef}, hi, 32'h0);
        checks++;
        if (result !== 32'hdeadbeef || wr_en !== 1'b1) begin
            fails++;
            $display("FAIL R6 constant build act=%h exp=%h", result, 32'hdeadbeef);
        end

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule